// File: doc/BRIEF.md
# TDM Per-Channel Output Switching Controller

This block decides, for every time slot of a serial TDM output stream, which byte goes out and whether the slot is driven at all. A connection entry of 32 bits is held for each output slot. The entry is split into a low 16-bit word and a high 16-bit word. One field of the entry picks one of three modes. In the switched mode the block fetches a byte from one of two input data memories. In the message mode it drives a constant byte taken from the entry. In the tristate mode it leaves the slot undriven.

A slot counter outside the block gives a strobe at the start of each output slot, together with the slot index and the parity of the frame. On that strobe the block reads the entry of the next slot, decodes it and fetches the byte. It holds the result in a staging register. On the following strobe the staged result becomes the output. The data memories are double-buffered by frame parity, so a switched byte always comes from the last complete input frame. Serialisation onto pins and the path that writes entries lie outside the block.

Top module: `tdm_chan_switch`

## Requirements
- R1: While reset is asserted, and after it is released, `out_en` is 0 and `out_byte` is 0. The first slot after reset is also undriven.
- R2: On each `slot_tick`, `cm_rd_en` is high in the same cycle and `cm_rd_addr` is `slot_idx+1`. When `slot_idx` is SLOTS-1, the address wraps to 0. The connection memory returns the entry one cycle after the read.
- R3: Entry layout: channel address in bits [CHAN_W-1:0] of the low word and stream address in the next STRM_W bits. The mode sits in high-word bits [1:0], with 00 switched, 01 message, 10 tristate and 11 tristate. The source select sits in high-word bit 2. In switched mode with select 0, the slot outputs the backplane data memory byte at address {bank, stream, channel}, with `out_en`=1.
- R4: In switched mode with select 1, the byte is read from the local data memory at the same address form instead, with `out_en`=1.
- R5: In message mode, the slot outputs the low 8 bits of the low word with `out_en`=1.
- R6: Modes 10 and 11 leave the slot with `out_en`=0 and `out_byte`=0.
- R7: The bank bit (data address MSB) is the inverse of the parity of the frame that owns the output slot. A lookup made on the last slot of a frame therefore uses the inverse of the next frame's parity.
- R8: `out_byte` and `out_en` change only on the clock edge that samples `slot_tick`. At that edge they take the result prepared for `slot_idx`. Strobes must be at least DM_LAT+2 cycles apart.
- R9: Each slot causes at most one data memory read, on the port chosen by the select bit, one cycle after its entry lookup. Message and tristate slots cause no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | Strobe at the start of an output slot |
| slot_idx | input | SLOT_W | Index of the slot now starting |
| frame_odd | input | 1 | Parity of the current frame |
| cm_rd_en | output | 1 | Connection memory read strobe |
| cm_rd_addr | output | SLOT_W | Slot whose entry is read |
| cm_rd_data | input | 32 | Entry, high word in [31:16], one cycle after the read |
| bp_rd_en | output | 1 | Backplane data memory read strobe |
| bp_rd_addr | output | DM_AW | {bank, stream, channel} |
| bp_rd_data | input | 8 | Backplane byte, DM_LAT cycles after the read |
| loc_rd_en | output | 1 | Local data memory read strobe |
| loc_rd_addr | output | DM_AW | {bank, stream, channel} |
| loc_rd_data | input | 8 | Local byte, DM_LAT cycles after the read |
| out_byte | output | 8 | Byte for the current slot |
| out_en | output | 1 | Slot is driven when high |

## Verification
On every strobe, two things happen on the same clock edge. The output register takes the staged result for the slot now starting, and the lookup for the following slot is launched. On the last slot of a frame that lookup also crosses the frame boundary and has to flip the bank. The bench runs strobes at the minimum useful spacing across several frames of alternating parity, with random entries and directed extreme entries. At each strobe edge it compares the output with a result the bench predicted one slot earlier. It also counts the data memory reads made between strobes, per port, and checks the bank bit through the expected byte.

// File: rtl/tdm_sw_pkg.sv
package tdm_sw_pkg;

   localparam int unsigned ENTRY_W = 32;
   localparam int unsigned HALF_W  = 16;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned SEL_BIT = 2;

   typedef enum logic [1:0] {
      MD_SWITCH = 2'b00,
      MD_MSG    = 2'b01,
      MD_TRI    = 2'b10,
      MD_RSV    = 2'b11
   } chan_mode_e;

   typedef struct packed {
      logic              valid;
      logic              use_bp;
      logic              use_loc;
      logic              drive;
      logic [BYTE_W-1:0] fixed;
   } slot_plan_t;

endpackage

// File: rtl/tdm_sw_slot_seq.sv
module tdm_sw_slot_seq #(
   parameter int SLOTS   = 32,
   parameter int SLOT_W  = 5,
   parameter int MIN_GAP = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_tick,
   input  logic [SLOT_W-1:0] slot_idx,
   input  logic              frame_odd,
   output logic              cm_rd_en,
   output logic [SLOT_W-1:0] cm_rd_addr,
   output logic              s1_valid,
   output logic              s1_bank
);
   localparam int GAP_W = $clog2(MIN_GAP + 1);

   logic             last_slot;
   logic [GAP_W-1:0] gap;

   assign last_slot  = (slot_idx == SLOT_W'(SLOTS - 1));
   assign cm_rd_en   = slot_tick;
   assign cm_rd_addr = last_slot ? '0 : slot_idx + SLOT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_bank  <= 1'b0;
      end else begin
         s1_valid <= slot_tick;
         if (slot_tick) s1_bank <= ~(frame_odd ^ last_slot);
      end
   end

   // cycles since the previous strobe, saturating at MIN_GAP
   always_ff @(posedge clk) begin
      if (!rst_n)                gap <= GAP_W'(MIN_GAP);
      else if (slot_tick)        gap <= GAP_W'(1);
      else if (gap < GAP_W'(MIN_GAP)) gap <= gap + GAP_W'(1);
   end

   assert_ahead_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cm_rd_en |-> ((cm_rd_addr == '0) == (slot_idx == SLOT_W'(SLOTS - 1))));

   assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      slot_tick |-> (gap >= GAP_W'(MIN_GAP)));

endmodule

// File: rtl/tdm_sw_entry_dec.sv
module tdm_sw_entry_dec
   import tdm_sw_pkg::*;
#(
   parameter int STRM_W = 6,
   parameter int CHAN_W = 9,
   parameter int DM_AW  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               s1_valid,
   input  logic               s1_bank,
   input  logic [ENTRY_W-1:0] cm_rd_data,
   output logic               bp_rd_en,
   output logic [DM_AW-1:0]   bp_rd_addr,
   output logic               loc_rd_en,
   output logic [DM_AW-1:0]   loc_rd_addr,
   output slot_plan_t         s2_plan
);
   logic [HALF_W-1:0] lo_w;
   logic [HALF_W-1:0] hi_w;
   chan_mode_e        mode;
   logic              src_loc;
   logic              fetch;
   logic [DM_AW-1:0]  dm_addr;
   slot_plan_t        plan_d;
   logic              unused_bits;

   assign lo_w    = cm_rd_data[HALF_W-1:0];
   assign hi_w    = cm_rd_data[ENTRY_W-1:HALF_W];
   assign mode    = chan_mode_e'(hi_w[1:0]);
   assign src_loc = hi_w[SEL_BIT];
   assign fetch   = s1_valid && (mode == MD_SWITCH);
   assign dm_addr = {s1_bank, lo_w[CHAN_W +: STRM_W], lo_w[CHAN_W-1:0]};

   generate
      if (STRM_W + CHAN_W < HALF_W) begin : g_spare
         assign unused_bits = ^{hi_w[HALF_W-1:SEL_BIT+1], lo_w[HALF_W-1:STRM_W+CHAN_W]};
      end else begin : g_full
         assign unused_bits = ^hi_w[HALF_W-1:SEL_BIT+1];
      end
   endgenerate

   assign bp_rd_en    = fetch && !src_loc;
   assign loc_rd_en   = fetch && src_loc;
   assign bp_rd_addr  = dm_addr;
   assign loc_rd_addr = dm_addr;

   always_comb begin
      plan_d         = '0;
      plan_d.valid   = s1_valid;
      plan_d.use_bp  = bp_rd_en;
      plan_d.use_loc = loc_rd_en;
      plan_d.drive   = (mode == MD_SWITCH) || (mode == MD_MSG);
      plan_d.fixed   = (mode == MD_MSG) ? lo_w[BYTE_W-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) s2_plan <= '0;
      else        s2_plan <= plan_d;
   end

   assert_single_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bp_rd_en, loc_rd_en}));

   assert_plan_marks_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_rd_en || loc_rd_en) |=> (s2_plan.drive && (s2_plan.fixed == '0)));

endmodule

// File: rtl/tdm_sw_out_stage.sv
module tdm_sw_out_stage
   import tdm_sw_pkg::*;
#(
   parameter int DM_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_tick,
   input  slot_plan_t        s2_plan,
   input  logic [BYTE_W-1:0] bp_rd_data,
   input  logic [BYTE_W-1:0] loc_rd_data,
   output logic [BYTE_W-1:0] out_byte,
   output logic              out_en
);
   slot_plan_t        s3_plan;
   logic              st_en;
   logic [BYTE_W-1:0] st_byte;

   generate
      if (DM_LAT == 1) begin : g_direct
         assign s3_plan = s2_plan;
      end else begin : g_delay
         slot_plan_t dly [DM_LAT-1];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DM_LAT-1; i++) dly[i] <= '0;
            end else begin
               dly[0] <= s2_plan;
               for (int i = 1; i < DM_LAT-1; i++) dly[i] <= dly[i-1];
            end
         end
         assign s3_plan = dly[DM_LAT-2];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_en   <= 1'b0;
         st_byte <= '0;
      end else if (s3_plan.valid) begin
         st_en   <= s3_plan.drive;
         st_byte <= s3_plan.use_bp  ? bp_rd_data  :
                    s3_plan.use_loc ? loc_rd_data : s3_plan.fixed;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_en   <= 1'b0;
         out_byte <= '0;
      end else if (slot_tick) begin
         out_en   <= st_en;
         out_byte <= st_byte;
      end
   end

   assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> (out_byte == '0));

   assert_hold_between_ticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_tick |=> ($stable(out_en) && $stable(out_byte)));

endmodule

// File: rtl/tdm_chan_switch.sv
module tdm_chan_switch
   import tdm_sw_pkg::*;
#(
   parameter  int SLOTS  = 32,
   parameter  int STRM_W = 6,
   parameter  int CHAN_W = 9,
   parameter  int DM_LAT = 1,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int DM_AW  = 1 + STRM_W + CHAN_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               slot_tick,
   input  logic [SLOT_W-1:0]  slot_idx,
   input  logic               frame_odd,
   output logic               cm_rd_en,
   output logic [SLOT_W-1:0]  cm_rd_addr,
   input  logic [ENTRY_W-1:0] cm_rd_data,
   output logic               bp_rd_en,
   output logic [DM_AW-1:0]   bp_rd_addr,
   input  logic [BYTE_W-1:0]  bp_rd_data,
   output logic               loc_rd_en,
   output logic [DM_AW-1:0]   loc_rd_addr,
   input  logic [BYTE_W-1:0]  loc_rd_data,
   output logic [BYTE_W-1:0]  out_byte,
   output logic               out_en
);
   localparam int MIN_GAP = DM_LAT + 2;

   generate
      if (SLOTS < 2)                 begin : g_bad_slots  $error("SLOTS must be at least 2"); end
      if (STRM_W + CHAN_W > HALF_W)  begin : g_bad_fields $error("stream and channel fields exceed the low word"); end
      if (DM_LAT < 1 || DM_LAT > 4)  begin : g_bad_lat    $error("DM_LAT must be 1 to 4"); end
   endgenerate

   logic       s1_valid;
   logic       s1_bank;
   slot_plan_t s2_plan;

   tdm_sw_slot_seq #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .MIN_GAP(MIN_GAP)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_tick  (slot_tick),
      .slot_idx   (slot_idx),
      .frame_odd  (frame_odd),
      .cm_rd_en   (cm_rd_en),
      .cm_rd_addr (cm_rd_addr),
      .s1_valid   (s1_valid),
      .s1_bank    (s1_bank)
   );

   tdm_sw_entry_dec #(.STRM_W(STRM_W), .CHAN_W(CHAN_W), .DM_AW(DM_AW)) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .s1_valid    (s1_valid),
      .s1_bank     (s1_bank),
      .cm_rd_data  (cm_rd_data),
      .bp_rd_en    (bp_rd_en),
      .bp_rd_addr  (bp_rd_addr),
      .loc_rd_en   (loc_rd_en),
      .loc_rd_addr (loc_rd_addr),
      .s2_plan     (s2_plan)
   );

   tdm_sw_out_stage #(.DM_LAT(DM_LAT)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_tick   (slot_tick),
      .s2_plan     (s2_plan),
      .bp_rd_data  (bp_rd_data),
      .loc_rd_data (loc_rd_data),
      .out_byte    (out_byte),
      .out_en      (out_en)
   );

   assert_fetch_follows_lookup_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_rd_en || loc_rd_en) |-> $past(cm_rd_en));

endmodule

// File: tb/test_tdm_chan_switch.sv
module test_tdm_chan_switch;
   localparam int SLOTS  = 32;
   localparam int SLOT_W = 5;
   localparam int DM_AW  = 16;
   localparam int GAP    = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              slot_tick = 1'b0;
   logic [SLOT_W-1:0] slot_idx = '0;
   logic              frame_odd = 1'b0;
   logic              cm_rd_en;
   logic [SLOT_W-1:0] cm_rd_addr;
   logic [31:0]       cm_q = '0;
   logic              bp_rd_en, loc_rd_en;
   logic [DM_AW-1:0]  bp_rd_addr, loc_rd_addr;
   logic [7:0]        bp_q = '0, loc_q = '0;
   logic [7:0]        out_byte;
   logic              out_en;

   logic [31:0] cm_mem [SLOTS];
   int total = 0, bad = 0, n_bp = 0, n_loc = 0;
   bit done = 0;
   logic       exp_en;
   logic [7:0] exp_byte;
   int         exp_bp, exp_loc;
   string      exp_tag;

   always #4 clk = ~clk;

   tdm_chan_switch i_tdm_chan_switch (
      .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .slot_idx(slot_idx),
      .frame_odd(frame_odd), .cm_rd_en(cm_rd_en), .cm_rd_addr(cm_rd_addr),
      .cm_rd_data(cm_q), .bp_rd_en(bp_rd_en), .bp_rd_addr(bp_rd_addr),
      .bp_rd_data(bp_q), .loc_rd_en(loc_rd_en), .loc_rd_addr(loc_rd_addr),
      .loc_rd_data(loc_q), .out_byte(out_byte), .out_en(out_en));

   function automatic logic [7:0] dm_fn(input bit port, input logic [15:0] a);
      logic [15:0] h;
      h = (a * 16'd40503) ^ (port ? 16'h5A3C : 16'h0000);
      return h[15:8] ^ h[7:0];
   endfunction

   always @(posedge clk) begin
      if (cm_rd_en)  cm_q  <= cm_mem[cm_rd_addr];
      if (bp_rd_en)  bp_q  <= dm_fn(1'b0, bp_rd_addr);
      if (loc_rd_en) loc_q <= dm_fn(1'b1, loc_rd_addr);
      n_bp  = n_bp  + int'(bp_rd_en);
      n_loc = n_loc + int'(loc_rd_en);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // expected outcome of one entry, from R3..R7 and R9
   task automatic predict(input logic [31:0] e, input bit bank);
      logic [15:0] lo;
      lo = e[15:0];
      exp_bp = 0; exp_loc = 0;
      case (e[17:16])
         2'b00: begin
            exp_en   = 1'b1;
            exp_byte = dm_fn(e[18], {bank, lo[14:9], lo[8:0]});
            if (e[18]) begin exp_loc = 1; exp_tag = "R4,R7"; end
            else       begin exp_bp  = 1; exp_tag = "R3,R7"; end
         end
         2'b01:   begin exp_en = 1'b1; exp_byte = lo[7:0]; exp_tag = "R5"; end
         default: begin exp_en = 1'b0; exp_byte = 8'h00;   exp_tag = "R6"; end
      endcase
   endtask

   task automatic do_tick(input int slot, input bit odd);
      logic [SLOT_W-1:0] nxt;
      bit                last;
      logic [7:0]        held_b;
      logic              held_e;
      last = (slot == SLOTS - 1);
      nxt  = last ? '0 : SLOT_W'(slot + 1);
      @(negedge clk);
      slot_tick = 1'b1; slot_idx = SLOT_W'(slot); frame_odd = odd;
      #1;
      chk(cm_rd_en == 1'b1 && cm_rd_addr == nxt, "R2 lookup address", int'(cm_rd_addr), int'(nxt));
      chk(n_bp == exp_bp, "R9 backplane reads", n_bp, exp_bp);
      chk(n_loc == exp_loc, "R9 local reads", n_loc, exp_loc);
      @(negedge clk);
      slot_tick = 1'b0;
      chk(out_en == exp_en, {exp_tag, " R8 out_en"}, int'(out_en), int'(exp_en));
      chk(out_byte == exp_byte, {exp_tag, " R8 out_byte"}, int'(out_byte), int'(exp_byte));
      n_bp = 0; n_loc = 0;
      predict(cm_mem[nxt], ~(last ? ~odd : odd));
      held_b = out_byte; held_e = out_en;
      for (int k = 0; k < GAP - 2; k++) begin
         @(negedge clk);
         chk(out_byte == held_b && out_en == held_e, "R8 hold between ticks",
             int'({out_en, out_byte}), int'({held_e, held_b}));
      end
   endtask

   initial begin
      int seed_val;
      seed_val = $urandom(32'h00C0FFEE);
      for (int i = 0; i < SLOTS; i++) cm_mem[i] = $urandom;
      // directed corner entries
      cm_mem[0] = {16'h0000, 1'b0, 6'd63, 9'd511};        // backplane, max address
      cm_mem[1] = {16'h0004, 1'b0, 6'd0, 9'd0};           // local, address 0
      cm_mem[2] = {16'h0001, 16'h00FF};                   // message FF
      cm_mem[3] = {16'h0005, 16'hFF00};                   // message 00, select set
      cm_mem[4] = {16'h0002, 16'h7FFF};                   // tristate
      cm_mem[5] = {16'h0007, 16'h1234};                   // reserved mode as tristate
      exp_en = 1'b0; exp_byte = 8'h00; exp_bp = 0; exp_loc = 0; exp_tag = "R1";
      repeat (3) @(negedge clk);
      chk(out_en == 1'b0 && out_byte == 8'h00, "R1 in reset", int'({out_en, out_byte}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_en == 1'b0 && out_byte == 8'h00, "R1 after reset", int'({out_en, out_byte}), 0);
      n_bp = 0; n_loc = 0;
      for (int f = 0; f < 8; f++) begin
         if (f >= 3) for (int i = 0; i < SLOTS; i++) cm_mem[i] = $urandom;
         for (int s = 0; s < SLOTS; s++) do_tick(s, f[0]);
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule